// File: doc/BRIEF.md
# Multi-Mode Gated Event Timer

This block is a 16-bit up/down timer core with three ways of advancing its count. In timer mode it counts ticks of a free-running prescaler fed by the system clock. In gated mode it counts the same ticks, but only while an external gate pin sits at a programmable active level. In counter mode it counts chosen transitions on that same pin. A 3-bit select field changes meaning with the mode. In the two tick-driven modes it picks the prescale factor. In counter mode it picks the edge type.

Software controls the block through a run bit, a direction bit, an optional external direction pin with its own enable, and a parallel load of the count. When the count wraps in either direction, the block raises a single-cycle interrupt pulse and flips a toggle latch. That latch reaches the output only while an output enable is set. Both external pins pass through a two-flop synchroniser. The reset input is asserted asynchronously and released synchronously.

Top module: `gp_event_timer`

## Requirements
- R1: After reset the count is 0000h, `irq_o` is 0 and the toggle latch is 0.
- R2: With `mode_i` = 000b (timer) and `run_i` = 1, the count advances once every 2^(n+2) clock cycles, where n is `sel_i` (000b gives 4 cycles, 111b gives 512 cycles).
- R3: With `run_i` = 0 the count does not change in any mode.
- R4: With `mode_i` = 010b the count advances at the prescaled rate only while the synchronised gate pin is 0. With `mode_i` = 011b it advances only while the pin is 1. Otherwise it holds.
- R5: A change of level on the gate pin never produces an `irq_o` pulse by itself.
- R6: With `mode_i` = 001b (counter) the count moves once per synchronised pin transition of the selected type: `sel_i` = 001b counts rising edges, 010b counts falling edges and 011b counts both. Any other `sel_i` value gives no counting.
- R7: The count goes down when `dir_i` XOR (`ext_dir_en_i` AND synchronised `ext_dir_pin_i`) is 1, and up otherwise.
- R8: A step from FFFFh up to 0000h, or from 0000h down to FFFFh, raises `irq_o` for exactly one cycle and inverts the toggle latch. No other event changes the latch.
- R9: `tgl_o` equals the toggle latch while `out_en_i` = 1, and is 0 while `out_en_i` = 0.
- R10: `load_i` = 1 writes `load_val_i` into the count at the next edge. This takes priority over a step in the same cycle and raises no interrupt.
- R11: A `mode_i` value with bit 2 set (1xxb) stops all counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Operating mode select |
| sel_i | input | 3 | Prescale code (timer/gated modes) or edge code (counter mode) |
| run_i | input | 1 | Software run enable |
| dir_i | input | 1 | Software direction, 1 = down |
| ext_dir_en_i | input | 1 | Lets the external direction pin take part |
| ext_dir_pin_i | input | 1 | External direction pin, asynchronous |
| gate_pin_i | input | 1 | Gate / event pin, asynchronous |
| load_i | input | 1 | Parallel load strobe for the count |
| load_val_i | input | 16 | Value written by a load |
| out_en_i | input | 1 | Enables the toggle latch onto `tgl_o` |
| count_o | output | 16 | Current count |
| irq_o | output | 1 | One-cycle wrap interrupt pulse |
| tgl_o | output | 1 | Gated toggle-latch output |

## Verification
A count step and a parallel load can land in the same cycle. This matters most when the loaded value is FFFFh and the step would wrap. The bench holds `load_i` high with FFFFh for several full prescaler periods in timer mode, so prescaler ticks are certain to fall inside the load window. While the load is held, the count must stay at FFFFh and no interrupt may be seen. After `load_i` drops, exactly one wrap pulse must follow within one prescale period.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam logic [2:0] MODE_TIMER   = 3'b000;
  localparam logic [2:0] MODE_COUNT   = 3'b001;
  localparam logic [2:0] MODE_GATE_LO = 3'b010;
  localparam logic [2:0] MODE_GATE_HI = 3'b011;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_kind_e;

  function automatic edge_kind_e decode_edge(input logic [2:0] code);
    edge_kind_e k;
    case (code)
      3'b001:  k = EDGE_RISE;
      3'b010:  k = EDGE_FALL;
      3'b011:  k = EDGE_BOTH;
      default: k = EDGE_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int SEL_W = 3,
  parameter int MIN_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int PRE_W = (1 << SEL_W) - 1 + MIN_LOG;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < (int'(sel_i) + MIN_LOG));
    end
  end

  assign tick_o = &(pre_q | ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/gpt_step_ctrl.sv
module gpt_step_ctrl
  import gpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic [2:0] sel_i,
  input  logic       run_i,
  input  logic       pin_s_i,
  input  logic       tick_i,
  output logic       step_o
);

  logic       prev_q, prev_d;
  logic       rise, fall, edge_hit;
  edge_kind_e kind;

  always_comb begin
    prev_d = pin_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = pin_s_i & ~prev_q;
  assign fall = ~pin_s_i & prev_q;
  assign kind = decode_edge(sel_i);

  always_comb begin
    case (kind)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (mode_i)
      MODE_TIMER:   step_o = run_i & tick_i;
      MODE_COUNT:   step_o = run_i & edge_hit;
      MODE_GATE_LO,
      MODE_GATE_HI: step_o = run_i & tick_i & (pin_s_i == mode_i[0]);
      default:      step_o = 1'b0;
    endcase
  end

  // R6: a counter-mode step needs a synchronised pin transition
  a_r6_step_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_COUNT && step_o) |-> (pin_s_i != prev_q));

endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             latch_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             tgl_q, tgl_d;
  logic             wrap;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = 1'b0;
    tgl_d = tgl_q;
    wrap  = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (step_i) begin
      if (down_i) begin
        cnt_d = cnt_q - 1'b1;
        wrap  = (cnt_q == '0);
      end else begin
        cnt_d = cnt_q + 1'b1;
        wrap  = (cnt_q == '1);
      end
      if (wrap) begin
        irq_d = 1'b1;
        tgl_d = ~tgl_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      tgl_q <= tgl_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign irq_o   = irq_q;
  assign latch_o = tgl_q;

  // R8: an interrupt only follows a boundary wrap
  a_r8_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ((cnt_q == '0 && $past(cnt_q) == '1) ||
               (cnt_q == '1 && $past(cnt_q) == '0)));

  // R8: the latch moves only together with an interrupt
  a_r8_latch_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgl_q) |-> irq_q);

  // R3: no step and no load keeps the count
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(cnt_q));

  // R2: an accepted step always moves the count
  a_r2_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (cnt_q != $past(cnt_q)));

  // R10: a load wins and raises no interrupt
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i) && !irq_q));

endmodule

// File: rtl/gp_event_timer.sv
module gp_event_timer #(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             run_i,
  input  logic             dir_i,
  input  logic             ext_dir_en_i,
  input  logic             ext_dir_pin_i,
  input  logic             gate_pin_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             out_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             tgl_o
);

  localparam int PIN_N = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [PIN_N-1:0] pins_s;
  logic             gate_s, ext_dir_s;
  logic             tick, step, down;
  logic             latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  gpt_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i ({ext_dir_pin_i, gate_pin_i}),
    .sync_o  (pins_s)
  );
  assign gate_s    = pins_s[0];
  assign ext_dir_s = pins_s[1];

  gpt_prescaler #(.SEL_W(SEL_W), .MIN_LOG(2)) u_pre (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .sel_i  (sel_i),
    .tick_o (tick)
  );

  gpt_step_ctrl u_step (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .mode_i  (mode_i),
    .sel_i   (sel_i),
    .run_i   (run_i),
    .pin_s_i (gate_s),
    .tick_i  (tick),
    .step_o  (step)
  );

  assign down = dir_i ^ (ext_dir_en_i & ext_dir_s);

  gpt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .step_i     (step),
    .down_i     (down),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .cnt_o      (count_o),
    .irq_o      (irq_o),
    .latch_o    (latch)
  );

  assign tgl_o = out_en_i & latch;

  // R11: reserved modes never step
  a_r11_reserved_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_i[2] && !load_i) |=> $stable(count_o));

  // R9: output is low whenever the enable is low
  a_r9_out_gate: assert property (@(posedge clk) disable iff (!rst_core_n)
    !out_en_i |-> !tgl_o);

endmodule

// File: tb/gp_event_timer_tb.sv
`timescale 1ns/1ps
module gp_event_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode_i, sel_i;
  logic        run_i, dir_i, ext_dir_en_i, ext_dir_pin_i, gate_pin_i;
  logic        load_i, out_en_i;
  logic [15:0] load_val_i;
  logic [15:0] count_o;
  logic        irq_o, tgl_o;

  int n_chk = 0;
  int n_bad = 0;
  int irq_seen = 0;

  always #5 clk = ~clk;

  gp_event_timer u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sel_i(sel_i), .run_i(run_i),
    .dir_i(dir_i), .ext_dir_en_i(ext_dir_en_i), .ext_dir_pin_i(ext_dir_pin_i),
    .gate_pin_i(gate_pin_i), .load_i(load_i), .load_val_i(load_val_i),
    .out_en_i(out_en_i), .count_o(count_o), .irq_o(irq_o), .tgl_o(tgl_o)
  );

  always @(posedge clk) if (irq_o) irq_seen++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas(input int win, output int d);
    logic [15:0] c0;
    c0 = count_o;
    wait_n(win);
    d = int'(16'(count_o - c0));
  endtask

  task automatic do_load(input logic [15:0] v);
    load_val_i = v; load_i = 1'b1;
    wait_n(1);
    load_i = 1'b0;
  endtask

  task automatic pin_pairs(input int n);
    for (int k = 0; k < n; k++) begin
      gate_pin_i = 1'b1; wait_n(4);
      gate_pin_i = 1'b0; wait_n(4);
    end
    wait_n(4);
  endtask

  initial begin
    wait_n(200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int d, i0, l0;
    rst_n = 1'b0; mode_i = 3'b000; sel_i = 3'b000; run_i = 1'b0; dir_i = 1'b0;
    ext_dir_en_i = 1'b0; ext_dir_pin_i = 1'b0; gate_pin_i = 1'b0;
    load_i = 1'b0; load_val_i = '0; out_en_i = 1'b1;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1 count", int'(count_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 latch", int'(tgl_o), 0);

    // R2 timer mode prescale sweep
    run_i = 1'b1;
    for (int s = 0; s < 8; s++) begin
      sel_i = 3'(s); wait_n(4);
      meas(2 << (s + 2), d);
      chk($sformatf("R2 sel %0d", s), d, 2);
    end
    // R3 run off
    run_i = 1'b0; sel_i = 3'b000; wait_n(2);
    meas(64, d); chk("R3 timer stopped", d, 0);

    // R7 direction combinations
    run_i = 1'b1; dir_i = 1'b1; wait_n(4);
    meas(16, d); chk("R7 sw down", d, 65532);
    dir_i = 1'b0; ext_dir_en_i = 1'b1; ext_dir_pin_i = 1'b1; wait_n(4);
    meas(16, d); chk("R7 pin down", d, 65532);
    ext_dir_en_i = 1'b0; wait_n(4);
    meas(16, d); chk("R7 pin masked", d, 4);
    dir_i = 1'b1; ext_dir_en_i = 1'b1; wait_n(4);
    meas(16, d); chk("R7 xor up", d, 4);
    dir_i = 1'b0; ext_dir_en_i = 1'b0; ext_dir_pin_i = 1'b0;

    // R4 gated sweep
    for (int p = 0; p < 2; p++)
      for (int lv = 0; lv < 2; lv++)
        for (int s = 0; s < 8; s++) begin
          mode_i = 3'(2 + p); gate_pin_i = 1'(lv); sel_i = 3'(s); wait_n(4);
          meas(2 << (s + 2), d);
          chk($sformatf("R4 pol %0d lvl %0d sel %0d", p, lv, s), d, (lv == p) ? 2 : 0);
        end
    mode_i = 3'b010; gate_pin_i = 1'b0; sel_i = 3'b000; run_i = 1'b0; wait_n(4);
    meas(64, d); chk("R3 gated stopped", d, 0);

    // R5 gate toggling raises no interrupt
    run_i = 1'b1; do_load(16'd5); i0 = irq_seen;
    for (int k = 0; k < 20; k++) begin
      gate_pin_i = ~gate_pin_i; wait_n(3);
    end
    gate_pin_i = 1'b0; wait_n(4);
    chk("R5 no gate irq", irq_seen - i0, 0);

    // R6 counter mode edge selection sweep
    mode_i = 3'b001; gate_pin_i = 1'b0;
    for (int s = 0; s < 8; s++) begin
      sel_i = 3'(s); wait_n(4); do_load(16'd0); wait_n(2);
      pin_pairs(3);
      chk($sformatf("R6 sel %0d", s), int'(count_o),
          (s == 1 || s == 2) ? 3 : (s == 3) ? 6 : 0);
    end
    sel_i = 3'b011; run_i = 1'b0; do_load(16'd0);
    pin_pairs(2);
    chk("R3 counter stopped", int'(count_o), 0);

    // R11 reserved modes
    run_i = 1'b1;
    for (int m = 4; m < 8; m++) begin
      mode_i = 3'(m); sel_i = 3'b000; wait_n(2);
      meas(64, d); chk($sformatf("R11 mode %0d", m), d, 0);
    end

    // R8 wrap up then down, R9 output enable
    mode_i = 3'b001; sel_i = 3'b011; gate_pin_i = 1'b0; wait_n(4);
    do_load(16'hFFFF); i0 = irq_seen; l0 = int'(tgl_o);
    gate_pin_i = 1'b1; wait_n(6);
    chk("R8 up wrap count", int'(count_o), 0);
    chk("R8 up wrap irq", irq_seen - i0, 1);
    chk("R8 up wrap latch", int'(tgl_o), 1 - l0);
    out_en_i = 1'b0; wait_n(1);
    chk("R9 disabled", int'(tgl_o), 0);
    out_en_i = 1'b1; wait_n(1);
    chk("R9 enabled", int'(tgl_o), 1);
    ext_dir_en_i = 1'b1; ext_dir_pin_i = 1'b1; wait_n(4);
    i0 = irq_seen;
    gate_pin_i = 1'b0; wait_n(6);
    chk("R8 down wrap count", int'(count_o), 65535);
    chk("R8 down wrap irq", irq_seen - i0, 1);
    chk("R8 down wrap latch", int'(tgl_o), 0);
    ext_dir_en_i = 1'b0; ext_dir_pin_i = 1'b0; wait_n(4);

    // R10 load held across ticks
    mode_i = 3'b000; sel_i = 3'b000; i0 = irq_seen;
    load_val_i = 16'hFFFF; load_i = 1'b1; wait_n(16);
    chk("R10 held count", int'(count_o), 65535);
    chk("R10 no irq under load", irq_seen - i0, 0);
    load_i = 1'b0; wait_n(8);
    chk("R10 wrap after release", irq_seen - i0, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule